// File: doc/BRIEF.md
# DMA source address update unit

This block keeps the source address of one DMA channel. Each time the channel finishes a transfer, the address is held, moved up or moved down. The distance moved is set by the transfer size. The address can be confined to a naturally aligned repeat window of 2^N bytes. When a step leaves that window, the address wraps inside it and the bits above the window are left unchanged.

A window overflow can also stop the channel. In that case the channel's active bit is cleared and a sticky interrupt-request flag is set. In block mode, that stop is held back until the current block ends. Software restarts the channel by setting the active bit again, and the channel carries on from the address where it halted. The CPU interrupt line is the request flag gated by a channel interrupt enable. Bus arbitration and data movement are outside this block.

Top module: `dma_src_addr_unit`

## Requirements
- R1: After reset, the address is 0, and the active bit, the request flag and the interrupt line are all 0.
- R2: While active, each `xfer_done_i` updates the address as set by `mode_i`. Codes 00 and 01 hold it, 10 adds the step and 11 subtracts the step. While the channel is inactive, `xfer_done_i` leaves the address unchanged.
- R3: The step is set by `size_i`. Code 00 gives 1, code 01 gives 2, and codes 10 and 11 give 4.
- R4: When `ext_single_i` is 1, the address is held whatever `mode_i` says.
- R5: When `rpt_sel_i` = N is in the range 1 to 7, the window covers the low N address bits. A step that carries out of bit N-1, or borrows out of it, wraps those N bits and keeps the upper bits unchanged. When N = 0, there is no wrapping.
- R6: Outside block mode, an overflow with `rpt_irq_en_i` = 1 sets the request flag and clears the active bit. Both are visible in the cycle after the transfer strobe, with the address already wrapped.
- R7: In block mode, an overflow only marks a pending stop. The flag is set and the channel is stopped at the next `blk_end_i` while active, and this includes a block end in the same cycle as the overflow. A block end with nothing pending does nothing.
- R8: `irq_o` is 1 exactly when the request flag is 1 and `irq_en_i` is 1.
- R9: Setting `act_set_i` after an overflow stop reactivates the channel at the address it held. Later transfers continue from that address.
- R10: When `rpt_sel_i` = 0, `rpt_irq_en_i` has no effect. When `rpt_irq_en_i` = 0, an overflow only wraps and the channel stays active.
- R11: The request flag stays set until `irf_clr_i` clears it. If a new overflow stop arrives in the same cycle as a clear, the flag stays 1.
- R12: `addr_wr_i` loads `addr_wdata_i` only while the channel is inactive. While the channel is active, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Address update mode |
| size_i | input | 2 | Transfer size code |
| rpt_sel_i | input | RPT_W | Repeat window exponent N, 0 = no window |
| rpt_irq_en_i | input | 1 | Stop and flag on window overflow |
| blk_mode_i | input | 1 | Block transfer mode |
| xfer_done_i | input | 1 | One transfer completed |
| blk_end_i | input | 1 | Current block finished |
| irq_en_i | input | 1 | Channel interrupt enable |
| ext_single_i | input | 1 | Single-address mode with external device as source |
| addr_wr_i | input | 1 | Software write of the address |
| addr_wdata_i | input | ADDR_W | Address write data |
| act_set_i | input | 1 | Software sets the active bit |
| irf_clr_i | input | 1 | Write-one-to-clear of the request flag |
| addr_o | output | ADDR_W | Current source address |
| active_o | output | 1 | Channel active bit |
| irf_o | output | 1 | Interrupt-request flag |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
Two events can land in the same cycle. In block mode, an overflowing transfer can coincide with a block end. A new overflow stop can also coincide with a software flag clear. The bench raises the strobes of each pair on the same edge. For the block-end pair, it expects the flag set, the channel stopped and the address already wrapped in the very next cycle. For the clear pair, it expects the flag to remain set, because the stop takes precedence over the clear.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    localparam int STEP_W = 3;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/dsa_step_gen.sv
module dsa_step_gen
    import dsa_pkg::*;
(
    input  logic [1:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic              ext_single_i,
    output step_dir_e         dir_o,
    output logic [STEP_W-1:0] step_o
);

    always_comb begin
        unique case (size_i)
            2'b00:   step_o = STEP_W'(1);
            2'b01:   step_o = STEP_W'(2);
            default: step_o = STEP_W'(4);
        endcase
    end

    always_comb begin
        if (ext_single_i || !mode_i[1]) begin
            dir_o = DIR_HOLD;
        end else if (mode_i[0]) begin
            dir_o = DIR_DOWN;
        end else begin
            dir_o = DIR_UP;
        end
    end

endmodule

// File: rtl/dsa_wrap_calc.sv
module dsa_wrap_calc
    import dsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RPT_W  = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  step_dir_e         dir_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [RPT_W-1:0]  rpt_sel_i,
    output logic [ADDR_W-1:0] addr_nxt_o,
    output logic              ovf_o
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] step_a;
    logic [ADDR_W-1:0] low;
    logic [ADDR_W-1:0] raw;
    logic              ovf_raw;
    logic              rpt_on;

    always_comb begin
        rpt_on  = (rpt_sel_i != '0);
        mask    = (ONE << rpt_sel_i) - ONE;
        step_a  = {{(ADDR_W-STEP_W){1'b0}}, step_i};
        low     = addr_i & mask;
        raw     = addr_i;
        ovf_raw = 1'b0;
        unique case (dir_i)
            DIR_UP: begin
                raw     = addr_i + step_a;
                ovf_raw = ({1'b0, low} + {1'b0, step_a}) > {1'b0, mask};
            end
            DIR_DOWN: begin
                raw     = addr_i - step_a;
                ovf_raw = (low < step_a);
            end
            default: begin
                raw     = addr_i;
                ovf_raw = 1'b0;
            end
        endcase
        if (rpt_on) begin
            addr_nxt_o = (addr_i & ~mask) | (raw & mask);
            ovf_o      = ovf_raw;
        end else begin
            addr_nxt_o = raw;
            ovf_o      = 1'b0;
        end
    end

endmodule

// File: rtl/dsa_stop_ctrl.sv
module dsa_stop_ctrl (
    input  logic blk_mode_i,
    input  logic blk_end_i,
    input  logic active_i,
    input  logic ovf_evt_i,
    input  logic pend_i,
    output logic raise_o,
    output logic pend_nxt_o
);

    logic pend_any;

    always_comb begin
        pend_any = pend_i | ovf_evt_i;
        if (blk_mode_i) begin
            raise_o    = active_i & blk_end_i & pend_any;
            pend_nxt_o = raise_o ? 1'b0 : pend_any;
        end else begin
            raise_o    = ovf_evt_i;
            pend_nxt_o = raise_o ? 1'b0 : pend_i;
        end
    end

endmodule

// File: rtl/dma_src_addr_unit.sv
module dma_src_addr_unit
    import dsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RPT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [RPT_W-1:0]  rpt_sel_i,
    input  logic              rpt_irq_en_i,
    input  logic              blk_mode_i,
    input  logic              xfer_done_i,
    input  logic              blk_end_i,
    input  logic              irq_en_i,
    input  logic              ext_single_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    input  logic              act_set_i,
    input  logic              irf_clr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              active_o,
    output logic              irf_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              active;
        logic              irf;
        logic              pend;
    } state_t;

    state_t state_d, state_q;

    step_dir_e         dir;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] addr_nxt;
    logic              ovf;
    logic              upd;
    logic              ovf_evt;
    logic              raise;
    logic              pend_nxt;

    dsa_step_gen u_step (
        .mode_i       (mode_i),
        .size_i       (size_i),
        .ext_single_i (ext_single_i),
        .dir_o        (dir),
        .step_o       (step)
    );

    dsa_wrap_calc #(
        .ADDR_W (ADDR_W),
        .RPT_W  (RPT_W)
    ) u_wrap (
        .addr_i     (state_q.addr),
        .dir_i      (dir),
        .step_i     (step),
        .rpt_sel_i  (rpt_sel_i),
        .addr_nxt_o (addr_nxt),
        .ovf_o      (ovf)
    );

    assign upd     = state_q.active & xfer_done_i;
    assign ovf_evt = upd & ovf & rpt_irq_en_i & (rpt_sel_i != '0);

    dsa_stop_ctrl u_stop (
        .blk_mode_i (blk_mode_i),
        .blk_end_i  (blk_end_i),
        .active_i   (state_q.active),
        .ovf_evt_i  (ovf_evt),
        .pend_i     (state_q.pend),
        .raise_o    (raise),
        .pend_nxt_o (pend_nxt)
    );

    always_comb begin
        state_d = state_q;
        if (upd) begin
            state_d.addr = addr_nxt;
        end else if (!state_q.active && addr_wr_i) begin
            state_d.addr = addr_wdata_i;
        end
        if (act_set_i) begin
            state_d.active = 1'b1;
        end
        if (raise) begin
            state_d.active = 1'b0;
        end
        if (irf_clr_i) begin
            state_d.irf = 1'b0;
        end
        if (raise) begin
            state_d.irf = 1'b1;
        end
        state_d.pend = pend_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign addr_o   = state_q.addr;
    assign active_o = state_q.active;
    assign irf_o    = state_q.irf;
    assign irq_o    = state_q.irf & irq_en_i;

endmodule

// File: rtl/dsa_src_chk.sv
module dsa_src_chk #(
    parameter int ADDR_W = 32,
    parameter int RPT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RPT_W-1:0]  rpt_sel_i,
    input logic              xfer_done_i,
    input logic              ext_single_i,
    input logic              addr_wr_i,
    input logic              irf_clr_i,
    input logic              irq_en_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              active_o,
    input logic              irf_o,
    input logic              irq_o
);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !addr_wr_i) |=> $stable(addr_o));

    // R4
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && ext_single_i) |=> $stable(addr_o));

    // R12
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && addr_wr_i && !xfer_done_i) |=> $stable(addr_o));

    // R5
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && xfer_done_i && rpt_sel_i != '0) |=>
        ((addr_o >> $past(rpt_sel_i)) == ($past(addr_o) >> $past(rpt_sel_i))));

    // R6
    stop_on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irf_o) |-> !active_o);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irf_o && !irf_clr_i) |=> irf_o);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irf_o && irq_en_i));

endmodule

bind dma_src_addr_unit dsa_src_chk #(
    .ADDR_W (ADDR_W),
    .RPT_W  (RPT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rpt_sel_i    (rpt_sel_i),
    .xfer_done_i  (xfer_done_i),
    .ext_single_i (ext_single_i),
    .addr_wr_i    (addr_wr_i),
    .irf_clr_i    (irf_clr_i),
    .irq_en_i     (irq_en_i),
    .addr_o       (addr_o),
    .active_o     (active_o),
    .irf_o        (irf_o),
    .irq_o        (irq_o)
);

// File: tb/dma_src_addr_unit_bench.sv
`timescale 1ns/1ps
module dma_src_addr_unit_bench;

    localparam int ADDR_W = 32;
    localparam int RPT_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        mode_i;
    logic [1:0]        size_i;
    logic [RPT_W-1:0]  rpt_sel_i;
    logic              rpt_irq_en_i;
    logic              blk_mode_i;
    logic              xfer_done_i;
    logic              blk_end_i;
    logic              irq_en_i;
    logic              ext_single_i;
    logic              addr_wr_i;
    logic [ADDR_W-1:0] addr_wdata_i;
    logic              act_set_i;
    logic              irf_clr_i;
    logic [ADDR_W-1:0] addr_o;
    logic              active_o;
    logic              irf_o;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dma_src_addr_unit #(.ADDR_W(ADDR_W), .RPT_W(RPT_W)) u_dma_src_addr_unit (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .size_i(size_i),
        .rpt_sel_i(rpt_sel_i), .rpt_irq_en_i(rpt_irq_en_i), .blk_mode_i(blk_mode_i),
        .xfer_done_i(xfer_done_i), .blk_end_i(blk_end_i), .irq_en_i(irq_en_i),
        .ext_single_i(ext_single_i), .addr_wr_i(addr_wr_i), .addr_wdata_i(addr_wdata_i),
        .act_set_i(act_set_i), .irf_clr_i(irf_clr_i), .addr_o(addr_o),
        .active_o(active_o), .irf_o(irf_o), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mode_i = 2'b00; size_i = 2'b00; rpt_sel_i = '0; rpt_irq_en_i = 1'b0;
        blk_mode_i = 1'b0; xfer_done_i = 1'b0; blk_end_i = 1'b0; irq_en_i = 1'b0;
        ext_single_i = 1'b0; addr_wr_i = 1'b0; addr_wdata_i = '0;
        act_set_i = 1'b0; irf_clr_i = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic start(input logic [31:0] a);
        addr_wr_i = 1'b1; addr_wdata_i = a;
        tick();
        addr_wr_i = 1'b0; act_set_i = 1'b1;
        tick();
        act_set_i = 1'b0;
    endtask

    task automatic step(input logic [1:0] m, input logic [1:0] s);
        mode_i = m; size_i = s; xfer_done_i = 1'b1;
        tick();
        xfer_done_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 addr", addr_o, 32'h0);
        chk("R1 active", {31'b0, active_o}, 32'h0);
        chk("R1 irf", {31'b0, irf_o}, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_load();
        do_reset();
        addr_wr_i = 1'b1; addr_wdata_i = 32'h1000;
        tick();
        addr_wr_i = 1'b0;
        chk("R12 idle load", addr_o, 32'h1000);
        step(2'b10, 2'b00);
        chk("R2 idle done ignored", addr_o, 32'h1000);
        act_set_i = 1'b1;
        tick();
        act_set_i = 1'b0;
        addr_wr_i = 1'b1; addr_wdata_i = 32'h2000;
        tick();
        addr_wr_i = 1'b0;
        chk("R12 busy write ignored", addr_o, 32'h1000);
    endtask

    task automatic t_modes();
        do_reset();
        start(32'h100);
        step(2'b10, 2'b00); chk("R3 byte inc", addr_o, 32'h101);
        step(2'b10, 2'b01); chk("R3 word inc", addr_o, 32'h103);
        step(2'b10, 2'b10); chk("R3 long inc", addr_o, 32'h107);
        step(2'b10, 2'b11); chk("R3 code 11 inc", addr_o, 32'h10B);
        step(2'b11, 2'b01); chk("R2 dec", addr_o, 32'h109);
        step(2'b00, 2'b10); chk("R2 mode 00 hold", addr_o, 32'h109);
        step(2'b01, 2'b10); chk("R2 mode 01 hold", addr_o, 32'h109);
        ext_single_i = 1'b1;
        step(2'b10, 2'b10); chk("R4 ext inc held", addr_o, 32'h109);
        step(2'b11, 2'b00); chk("R4 ext dec held", addr_o, 32'h109);
        ext_single_i = 1'b0;
    endtask

    task automatic t_wrap();
        do_reset();
        rpt_sel_i = 3'd4;
        start(32'h20C);
        step(2'b10, 2'b10);
        chk("R5 inc wrap", addr_o, 32'h200);
        chk("R10 no stop when disabled", {31'b0, active_o}, 32'h1);
        chk("R10 no flag when disabled", {31'b0, irf_o}, 32'h0);
        step(2'b11, 2'b00);
        chk("R5 dec wrap", addr_o, 32'h20F);
        do_reset();
        rpt_sel_i = 3'd0; rpt_irq_en_i = 1'b1;
        start(32'h2FF);
        step(2'b10, 2'b00);
        chk("R5 no window carry", addr_o, 32'h300);
        chk("R10 no window active", {31'b0, active_o}, 32'h1);
        chk("R10 no window flag", {31'b0, irf_o}, 32'h0);
    endtask

    task automatic t_stop();
        do_reset();
        rpt_sel_i = 3'd3; rpt_irq_en_i = 1'b1;
        start(32'h406);
        step(2'b10, 2'b01);
        chk("R6 wrapped addr", addr_o, 32'h400);
        chk("R6 flag", {31'b0, irf_o}, 32'h1);
        chk("R6 stopped", {31'b0, active_o}, 32'h0);
        chk("R8 irq gated off", {31'b0, irq_o}, 32'h0);
        irq_en_i = 1'b1;
        #1;
        chk("R8 irq on", {31'b0, irq_o}, 32'h1);
        step(2'b10, 2'b01);
        chk("R2 stopped done ignored", addr_o, 32'h400);
        act_set_i = 1'b1;
        tick();
        act_set_i = 1'b0;
        chk("R9 resumed", {31'b0, active_o}, 32'h1);
        chk("R9 addr kept", addr_o, 32'h400);
        step(2'b10, 2'b01);
        chk("R9 continues", addr_o, 32'h402);
        chk("R11 flag sticky", {31'b0, irf_o}, 32'h1);
        irf_clr_i = 1'b1;
        tick();
        irf_clr_i = 1'b0;
        chk("R11 cleared", {31'b0, irf_o}, 32'h0);
        chk("R8 irq off", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_block();
        do_reset();
        blk_mode_i = 1'b1; rpt_sel_i = 3'd2; rpt_irq_en_i = 1'b1;
        start(32'h503);
        blk_end_i = 1'b1;
        tick();
        blk_end_i = 1'b0;
        chk("R7 idle block end", {31'b0, irf_o, active_o}, 32'h1);
        step(2'b10, 2'b00);
        chk("R7 deferred addr", addr_o, 32'h500);
        chk("R7 deferred active", {31'b0, active_o}, 32'h1);
        chk("R7 deferred flag", {31'b0, irf_o}, 32'h0);
        step(2'b10, 2'b00);
        chk("R7 keeps moving", addr_o, 32'h501);
        blk_end_i = 1'b1;
        tick();
        blk_end_i = 1'b0;
        chk("R7 raised at end", {31'b0, irf_o, active_o}, 32'h2);
    endtask

    task automatic t_coincide();
        do_reset();
        blk_mode_i = 1'b1; rpt_sel_i = 3'd2; rpt_irq_en_i = 1'b1;
        start(32'h603);
        blk_end_i = 1'b1;
        step(2'b10, 2'b00);
        blk_end_i = 1'b0;
        chk("R7 same cycle addr", addr_o, 32'h600);
        chk("R7 same cycle stop", {31'b0, irf_o, active_o}, 32'h2);
        do_reset();
        rpt_sel_i = 3'd3; rpt_irq_en_i = 1'b1;
        start(32'h707);
        step(2'b10, 2'b00);
        chk("R6 first stop", {31'b0, irf_o, active_o}, 32'h2);
        act_set_i = 1'b1;
        tick();
        act_set_i = 1'b0;
        irf_clr_i = 1'b1;
        step(2'b11, 2'b00);
        irf_clr_i = 1'b0;
        chk("R5 borrow wrap", addr_o, 32'h707);
        chk("R11 set beats clear", {31'b0, irf_o, active_o}, 32'h2);
    endtask

    initial begin
        t_reset();
        t_load();
        t_modes();
        t_wrap();
        t_stop();
        t_block();
        t_coincide();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule